// File: doc/BRIEF.md
# Mode-Aware Effective Address Unit

This unit turns a decoded memory-operand descriptor into an effective address. The descriptor says whether a base register and an index register are used and which ones, gives a scale code and a displacement that is already sign-extended to 64 bits, and may ask for an address relative to the next instruction. The unit also takes the processor's addressing mode, an address-size override flag, the next-instruction pointer and the current values of all general registers.

Three address widths are supported. At 16 bits the base-select code picks one of eight fixed register pairs or single registers, with no scaled index. At 32 and 64 bits the address is base plus scaled index plus displacement. Instruction-relative addressing replaces the base with the next-instruction pointer. The sum is wrapped to the active width and zero-extended to 64 bits. It is presented one clock after a valid descriptor, together with a valid flag.

Top module: `ea_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ea_valid` and `ea` both become 0.
- R2: `ea_valid` is high in exactly the cycle after one with `req_valid` high and carries the address of that descriptor. After a cycle with `req_valid` low, `ea_valid` is low and `ea` keeps its previous value.
- R3: Width selection: `mode` 0 gives 16-bit, 1 gives 32-bit, 2 and 3 give 64-bit addressing. With `asize_ovr` set, 16-bit becomes 32-bit, 32-bit becomes 16-bit and 64-bit becomes 32-bit.
- R4: In 16-bit width with `base_en` high, `base_sel[2:0]` selects the base as follows. Register numbers are 0 AX, 3 BX, 5 BP, 6 SI, 7 DI. Codes 0 to 3 give BX+SI, BX+DI, BP+SI and BP+DI. Codes 4 to 7 give SI, DI, BP and BX. The displacement is added to the base.
- R5: In 16-bit width the index, scale and `ip_rel` inputs have no effect, only the low 16 bits of the operands count, and the sum wraps modulo 2^16 with `ea[63:16]` = 0.
- R6: In 32-bit and 64-bit width, the address is base + (index << `scale`) + `disp`, so `scale` 0..3 means a factor of 1, 2, 4 or 8.
- R7: In 32-bit width only the low 32 bits of every operand count, the sum wraps modulo 2^32, and `ea[63:32]` = 0.
- R8: In 64-bit width full 64-bit register values are used and the sum wraps modulo 2^64.
- R9: An absent base (`base_en` low) or an absent index (`index_en` low) contributes zero, in every width.
- R10: In 32-bit and 64-bit width, `ip_rel` high replaces the base term with `next_ip`; at 32-bit width only its low 32 bits count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Descriptor valid this cycle |
| mode | input | 2 | Addressing mode: 0 16-bit, 1 32-bit, 2/3 64-bit |
| asize_ovr | input | 1 | Address-size override |
| base_en | input | 1 | Base term present |
| base_sel | input | 4 | Base register number (16-bit: pair code in bits 2:0) |
| index_en | input | 1 | Index term present |
| index_sel | input | 4 | Index register number |
| scale | input | 2 | Index shift amount (factor 1, 2, 4, 8) |
| disp | input | 64 | Sign-extended displacement |
| ip_rel | input | 1 | Address relative to next instruction |
| next_ip | input | 64 | Address of the next instruction |
| regs_flat | input | 1024 | Register values, register n in bits 64n+63:64n |
| ea_valid | output | 1 | Effective address valid |
| ea | output | 64 | Effective address, zero-extended |

## Verification
A wrong width decision appears in the next cycle as nonzero upper address bits or as a missing wrap-around. Every mode and override pairing is swept, with register values whose upper halves are nonzero, so such a fault cannot stay hidden. A wrong pair decode or term selection gives a wrong sum one cycle after the descriptor. The sweep covers every base and index register, every scale, and both present and absent terms. Pipeline faults show up as a valid flag that does not track `req_valid` one cycle later, or as an address that changes while no request is made.

// File: rtl/ea_pkg.sv
// Shared types for the effective address unit.
// Assumes a 2-bit width code and the fixed 16-bit register numbering below.
package ea_pkg;
    typedef enum logic [1:0] {
        AW16 = 2'd0,
        AW32 = 2'd1,
        AW64 = 2'd2
    } aw_e;

    // Register numbers used by the 16-bit pair decode
    localparam int RN_BX = 3;
    localparam int RN_BP = 5;
    localparam int RN_SI = 6;
    localparam int RN_DI = 7;
endpackage

// File: rtl/ea_width_sel.sv
// Resolves the active address width from the mode and the size override.
// Assumes mode code 3 behaves as 64-bit mode.
module ea_width_sel
    import ea_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       asize_ovr,
    output aw_e        width
);
    // Map the mode and override to the address width
    always_comb begin
        unique case (mode)
            2'd0:    width = asize_ovr ? AW32 : AW16;
            2'd1:    width = asize_ovr ? AW16 : AW32;
            default: width = asize_ovr ? AW32 : AW64;
        endcase
    end
endmodule

// File: rtl/ea_operand_sel.sv
// Picks the two register-derived terms of the address sum.
// At 16-bit width: the base pair (or single register) from base_sel[2:0].
// At 32/64-bit width: base or next-instruction pointer, and the scaled index.
// Assumes NREG >= 8 so the fixed 16-bit register numbers exist.
module ea_operand_sel
    import ea_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  aw_e                   width,
    input  logic                  base_en,
    input  logic [IDXW-1:0]       base_sel,
    input  logic                  index_en,
    input  logic [IDXW-1:0]       index_sel,
    input  logic [1:0]            scale,
    input  logic                  ip_rel,
    input  logic [XLEN-1:0]       next_ip,
    input  logic [NREG*XLEN-1:0]  regs_flat,
    output logic [XLEN-1:0]       term_a,
    output logic [XLEN-1:0]       term_b
);
    logic [XLEN-1:0] rf [NREG];

    // Unpack the flat register bus
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign rf[g] = regs_flat[g*XLEN +: XLEN];
    end

    // Select the terms by width
    always_comb begin
        term_a = '0;
        term_b = '0;
        if (width == AW16) begin
            if (base_en) begin
                unique case (base_sel[2:0])
                    3'd0: begin term_a = rf[RN_BX]; term_b = rf[RN_SI]; end
                    3'd1: begin term_a = rf[RN_BX]; term_b = rf[RN_DI]; end
                    3'd2: begin term_a = rf[RN_BP]; term_b = rf[RN_SI]; end
                    3'd3: begin term_a = rf[RN_BP]; term_b = rf[RN_DI]; end
                    3'd4: term_a = rf[RN_SI];
                    3'd5: term_a = rf[RN_DI];
                    3'd6: term_a = rf[RN_BP];
                    default: term_a = rf[RN_BX];
                endcase
            end
        end else begin
            if (ip_rel)       term_a = next_ip;
            else if (base_en) term_a = rf[base_sel];
            if (index_en)     term_b = rf[index_sel] << scale;
        end
    end
endmodule

// File: rtl/ea_adder.sv
// Three-input address adder with wrap to the active width.
// Assumes XLEN >= 32; the result is zero-extended above the width.
module ea_adder
    import ea_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  aw_e             width,
    input  logic [XLEN-1:0] term_a,
    input  logic [XLEN-1:0] term_b,
    input  logic [XLEN-1:0] disp,
    output logic [XLEN-1:0] sum
);
    localparam logic [XLEN-1:0] MASK16 = {{(XLEN-16){1'b0}}, {16{1'b1}}};
    localparam logic [XLEN-1:0] MASK32 = {{(XLEN-32){1'b0}}, {32{1'b1}}};

    logic [XLEN-1:0] raw;

    // Add the terms and truncate to the width
    always_comb begin
        raw = term_a + term_b + disp;
        unique case (width)
            AW16:    sum = raw & MASK16;
            AW32:    sum = raw & MASK32;
            default: sum = raw;
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
// Effective address unit: width resolution, term selection, add and a
// one-cycle output register with valid flag.
// Assumes register values arrive in the same cycle as the descriptor.
module ea_unit
    import ea_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            mode,
    input  logic                  asize_ovr,
    input  logic                  base_en,
    input  logic [IDXW-1:0]       base_sel,
    input  logic                  index_en,
    input  logic [IDXW-1:0]       index_sel,
    input  logic [1:0]            scale,
    input  logic [XLEN-1:0]       disp,
    input  logic                  ip_rel,
    input  logic [XLEN-1:0]       next_ip,
    input  logic [NREG*XLEN-1:0]  regs_flat,
    output logic                  ea_valid,
    output logic [XLEN-1:0]       ea
);
    aw_e             width;
    logic [XLEN-1:0] term_a;
    logic [XLEN-1:0] term_b;
    logic [XLEN-1:0] sum;

    ea_width_sel u_width (
        .mode      (mode),
        .asize_ovr (asize_ovr),
        .width     (width)
    );

    ea_operand_sel #(.XLEN(XLEN), .NREG(NREG)) u_opsel (
        .width     (width),
        .base_en   (base_en),
        .base_sel  (base_sel),
        .index_en  (index_en),
        .index_sel (index_sel),
        .scale     (scale),
        .ip_rel    (ip_rel),
        .next_ip   (next_ip),
        .regs_flat (regs_flat),
        .term_a    (term_a),
        .term_b    (term_b)
    );

    ea_adder #(.XLEN(XLEN)) u_add (
        .width  (width),
        .term_a (term_a),
        .term_b (term_b),
        .disp   (disp),
        .sum    (sum)
    );

    // Output register: capture on a valid descriptor, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            ea       <= '0;
        end else begin
            ea_valid <= req_valid;
            if (req_valid) ea <= sum;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ea_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ea_valid);
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(ea));
    a_r5_w16_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && width == AW16) |=> (ea[XLEN-1:16] == '0));
    a_r7_w32_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && width == AW32) |=> (ea[XLEN-1:32] == '0));
endmodule

// File: tb/ea_unit_tb_top.sv
// Sweep bench for ea_unit: every mode, override, base/index choice, scale
// and relative flag, with expected addresses computed arithmetically.
module ea_unit_tb_top;
    localparam int XLEN = 64;
    localparam int NREG = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic [1:0]           mode = '0;
    logic                 asize_ovr = 1'b0;
    logic                 base_en = 1'b0;
    logic [3:0]           base_sel = '0;
    logic                 index_en = 1'b0;
    logic [3:0]           index_sel = '0;
    logic [1:0]           scale = '0;
    logic [XLEN-1:0]      disp = '0;
    logic                 ip_rel = 1'b0;
    logic [XLEN-1:0]      next_ip = '0;
    logic [NREG*XLEN-1:0] regs_flat;
    logic                 ea_valid;
    logic [XLEN-1:0]      ea;

    logic [XLEN-1:0] rf [NREG];
    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NREG; g++) begin : g_pack
        assign regs_flat[g*XLEN +: XLEN] = rf[g];
    end

    ea_unit #(.XLEN(XLEN), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .asize_ovr(asize_ovr), .base_en(base_en), .base_sel(base_sel),
        .index_en(index_en), .index_sel(index_sel), .scale(scale),
        .disp(disp), .ip_rel(ip_rel), .next_ip(next_ip),
        .regs_flat(regs_flat), .ea_valid(ea_valid), .ea(ea)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Width in bits per R3
    function automatic int width_of(input int m, input bit o);
        if (m == 0) return o ? 32 : 16;
        if (m == 1) return o ? 16 : 32;
        return o ? 32 : 64;
    endfunction

    // Expected address per R4..R10
    function automatic logic [63:0] model(input int w, input bit be, input int bs,
                                          input bit ie, input int is, input int sc,
                                          input bit ip, input logic [63:0] d,
                                          input logic [63:0] nip);
        logic [63:0] s;
        if (w == 16) begin
            s = d;
            if (be) begin
                case (bs % 8)
                    0: s = s + rf[3] + rf[6];
                    1: s = s + rf[3] + rf[7];
                    2: s = s + rf[5] + rf[6];
                    3: s = s + rf[5] + rf[7];
                    4: s = s + rf[6];
                    5: s = s + rf[7];
                    6: s = s + rf[5];
                    default: s = s + rf[3];
                endcase
            end
            return {48'h0, s[15:0]};
        end
        s = d;
        if (ip)      s = s + nip;
        else if (be) s = s + rf[bs];
        if (ie)      s = s + rf[is] * (64'd1 << sc);
        if (w == 32) return {32'h0, s[31:0]};
        return s;
    endfunction

    function automatic string tag_of(input int w, input bit be, input bit ie, input bit ip);
        if (w == 16) return be ? "R4 R5" : "R5 R9";
        if (!be || !ie) return "R9";
        if (ip) return "R10";
        return (w == 32) ? "R7 R6" : "R8 R6";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] exp_ea;
        string       tag;
        bit          have;
        int          vn;
        logic [63:0] held;
        for (int i = 0; i < NREG; i++)
            rf[i] = 64'hFEDC_BA98_7654_3217 * 64'(i + 3) + 64'h0F0F_F0F0_8000_FFF0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", {63'h0, ea_valid}, 64'h0);
        check("R1 ea", ea, 64'h0);
        rst_n = 1'b1;

        have = 1'b0;
        vn = 0;
        exp_ea = '0;
        tag = "";
        for (int m = 0; m < 4; m++)
        for (int o = 0; o < 2; o++)
        for (int be = 0; be < 2; be++)
        for (int bs = 0; bs < 16; bs++)
        for (int ie = 0; ie < 2; ie++)
        for (int is = 0; is < 16; is++)
        for (int sc = 0; sc < 4; sc++)
        for (int ip = 0; ip < 2; ip++) begin
            logic [31:0] d32;
            logic [63:0] d64;
            logic [63:0] nip;
            int w;
            @(negedge clk);
            if (have) begin
                check("R2 valid", {63'h0, ea_valid}, 64'h1);
                check({tag, " R3"}, ea, exp_ea);
            end
            d32 = 32'(vn) * 32'h9E37_79B9;
            d64 = {{32{d32[31]}}, d32};
            nip = 64'hFFFF_FFFF_FFFF_F000 + 64'(vn) * 64'h0000_0001_0001_0013;
            w = width_of(m, o[0]);
            req_valid = 1'b1;
            mode      = 2'(m);
            asize_ovr = o[0];
            base_en   = be[0];
            base_sel  = 4'(bs);
            index_en  = ie[0];
            index_sel = 4'(is);
            scale     = 2'(sc);
            ip_rel    = ip[0];
            disp      = d64;
            next_ip   = nip;
            exp_ea = model(w, be[0], bs, ie[0], is, sc, ip[0], d64, nip);
            tag = tag_of(w, be[0], ie[0], ip[0]);
            have = 1'b1;
            vn++;
        end
        @(negedge clk);
        check({tag, " R3"}, ea, exp_ea);

        // R2: no request -> no valid, address held despite changed inputs
        held = ea;
        req_valid = 1'b0;
        mode = 2'd2;
        disp = 64'h1234_5678_9ABC_DEF0;
        base_en = 1'b1;
        @(negedge clk);
        check("R2 idle valid", {63'h0, ea_valid}, 64'h0);
        check("R2 idle hold", ea, held);
        @(negedge clk);
        check("R2 idle hold2", ea, held);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule